// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in the command path of a controller for a two-bank synchronous DRAM with 8-bit column addresses. It holds the burst mode that the controller programs with a mode-register-set cycle. For every read or write burst it produces the column address of each data beat. The programmed mode covers burst length, beat ordering, CAS latency and whether write bursts collapse to a single beat. The controller uses the beat stream to drive column commands or to index a data buffer. It uses the reported CAS latency to place read data.

A mode-set strobe presents the 12-bit address key and the bank bit. A legal key is latched. An illegal one raises an error flag and leaves the earlier mode in force. A start pulse with a starting column and a read/write flag launches a burst. From the next clock on, one column address appears per cycle, with a valid flag and a last-beat flag. A stop input ends any burst. A full-page burst ends only through stop.

Top module: `bca_burst_colgen`

## Requirements
- R1: After reset, col_valid, col_last and mode_err are 0, cas_lat reads 2 and the burst length is 1 beat with sequential ordering.
- R2: On mode_set with a legal key, the mode takes effect from the next cycle and mode_err reads 0. Key bits [2:0] hold the length code, bit 3 the ordering (1 = interleave), bits [6:4] the latency code (010 = 2, 011 = 3) and bit 9 the single-beat write flag. cas_lat shows the latched latency.
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. col_last is 1 only on the final beat, and col_valid falls in the cycle after it.
- R4: In sequential ordering, beat i carries the low log2(length) bits of (start + i), wrapping inside the length-aligned block. The column bits above that block equal the starting column.
- R5: In interleave ordering, beat i carries the low bits of (start XOR i). The bits above the block equal the starting column.
- R6: Length code 111 gives a sequential full-page burst. It walks all 256 columns, wraps from 255 to 0 and never asserts col_last.
- R7: With key bit 9 set, a burst started with start_wr = 1 has exactly one beat. Reads keep the programmed length. With bit 9 clear, writes use the programmed length.
- R8: A stop sampled at a clock edge makes col_valid 0 after that edge, for any length including full page. Stop wins over a start at the same edge.
- R9: A key with a reserved length code, a reserved latency code, interleave together with full page, a non-zero bit 7, 8, 10 or 11, or the bank bit set raises mode_err and keeps the previous mode. mode_err changes only after a mode_set, and the next legal key clears it.
- R10: The first beat, equal to start_col, is valid in the cycle after start, and beats follow on consecutive cycles. A start during a burst abandons it and begins the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_set | input | 1 | Mode-register-set strobe |
| mode_key | input | KEY_W | Address key sampled with mode_set |
| mode_bank | input | 1 | Bank bit sampled with mode_set; must be 0 |
| start | input | 1 | Burst start pulse |
| start_wr | input | 1 | 1 if the burst being started is a write |
| start_col | input | COL_W | Starting column of the burst |
| stop | input | 1 | Burst stop |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Last mode key was rejected |
| cas_lat | output | 2 | Programmed CAS latency in cycles |

## Verification
The bench builds the block with its default widths: 8 column bits and a 12-bit key. With these widths a full-page burst is exactly 256 beats, so a run of more than 256 beats shows the wrap from column 255 to 0 and the absence of any last flag. Every legal length and both orderings are exercised with starts that sit in the middle of their aligned blocks, so wrapping and XOR patterns both show in the upper and lower column bits. The stop, restart and single-beat write paths are driven at the same widths.

// File: rtl/bca_pkg.sv
package bca_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } blen_e;

  typedef struct packed {
    blen_e blen;
    logic  ileave;
    logic  cl3;
    logic  wr_single;
  } mode_t;

  localparam mode_t MODE_RST = '{blen: BL_1, ileave: 1'b0, cl3: 1'b0, wr_single: 1'b0};

  // key field positions (decoded by the mode register)
  localparam int KF_BL_LO = 0;
  localparam int KF_BT    = 3;
  localparam int KF_CL_LO = 4;
  localparam int KF_TM_LO = 7;
  localparam int KF_WB    = 9;
  localparam int KF_RFU   = 10;

endpackage

// File: rtl/bca_mode_reg.sv
module bca_mode_reg
  import bca_pkg::*;
#(
  parameter int KEY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic [KEY_W-1:0] key,
  input  logic             bank,
  output mode_t            mode,
  output logic             err
);

  logic [2:0] len_code;
  logic [2:0] cl_code;
  logic       len_ok, cl_ok, combo_ok, rsv_ok, key_ok;

  always_comb begin
    len_code = key[KF_BL_LO +: 3];
    cl_code  = key[KF_CL_LO +: 3];
    len_ok   = (len_code inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
    cl_ok    = (cl_code == 3'b010) || (cl_code == 3'b011);
    combo_ok = !((len_code == 3'b111) && key[KF_BT]);
    rsv_ok   = (key[KEY_W-1:KF_RFU] == '0) && (key[KF_TM_LO +: 2] == 2'b00) && !bank;
    key_ok   = len_ok && cl_ok && combo_ok && rsv_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_RST;
      err  <= 1'b0;
    end else if (set) begin
      err <= !key_ok;
      if (key_ok) begin
        mode.blen      <= blen_e'(len_code);
        mode.ileave    <= key[KF_BT];
        mode.cl3       <= cl_code[0];
        mode.wr_single <= key[KF_WB];
      end
    end
  end

endmodule

// File: rtl/bca_addr_map.sv
module bca_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ileave,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] low;

  assign low = ileave ? (base ^ beat) : (base + beat);

  // bits inside the burst block move, bits above it follow the start column
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? low[b] : base[b];
  end

endmodule

// File: rtl/bca_seq.sv
module bca_seq
  import bca_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  mode_t            mode,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic [COL_W-1:0] blk_mask
);

  logic [COL_W-1:0] base_q, cnt_q, cnt_nx;
  logic             full_q, il_q;
  logic [COL_W-1:0] mask_new, base_sel, beat_sel, mask_sel, map_col;
  logic             force_one, full_new, il_sel;

  always_comb begin
    force_one = start_wr && mode.wr_single;
    case (mode.blen)
      BL_2:    mask_new = COL_W'(1);
      BL_4:    mask_new = COL_W'(3);
      BL_8:    mask_new = COL_W'(7);
      BL_PAGE: mask_new = '1;
      default: mask_new = '0;
    endcase
    if (force_one) mask_new = '0;
    full_new = (mode.blen == BL_PAGE) && !force_one;
    cnt_nx   = cnt_q + 1'b1;
    base_sel = start ? start_col : base_q;
    beat_sel = start ? '0 : cnt_nx;
    mask_sel = start ? mask_new : blk_mask;
    il_sel   = start ? mode.ileave : il_q;
  end

  bca_addr_map #(.COL_W(COL_W)) u_map (
    .base   (base_sel),
    .beat   (beat_sel),
    .mask   (mask_sel),
    .ileave (il_sel),
    .col    (map_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      valid    <= 1'b0;
      last     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      blk_mask <= '0;
      full_q   <= 1'b0;
      il_q     <= 1'b0;
    end else if (stop) begin
      valid <= 1'b0;
      last  <= 1'b0;
    end else if (start) begin
      base_q   <= start_col;
      cnt_q    <= '0;
      blk_mask <= mask_new;
      full_q   <= full_new;
      il_q     <= mode.ileave;
      col      <= map_col;
      valid    <= 1'b1;
      last     <= (mask_new == '0);
    end else if (valid) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
        col   <= map_col;
        last  <= !full_q && (cnt_nx == blk_mask);
      end
    end
  end

endmodule

// File: rtl/bca_burst_colgen.sv
module bca_burst_colgen
  import bca_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int KEY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_set,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             mode_bank,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err,
  output logic [1:0]       cas_lat
);

  mode_t            mode;
  logic [COL_W-1:0] blk_mask;

  bca_mode_reg #(.KEY_W(KEY_W)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .set  (mode_set),
    .key  (mode_key),
    .bank (mode_bank),
    .mode (mode),
    .err  (mode_err)
  );

  bca_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_wr  (start_wr),
    .start_col (start_col),
    .stop      (stop),
    .mode      (mode),
    .col       (col_out),
    .valid     (col_valid),
    .last      (col_last),
    .blk_mask  (blk_mask)
  );

  assign cas_lat = mode.cl3 ? 2'd3 : 2'd2;

endmodule

// File: rtl/bca_burst_colgen_chk.sv
module bca_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_set,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             mode_err,
  input logic [1:0]       cas_lat,
  input logic [COL_W-1:0] blk_mask
);

  p_last_ends_r3: assert property (@(posedge clk) disable iff (rst)
    col_valid && col_last && !start |=> !col_valid);

  p_last_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
    col_valid && !col_last && !start && !stop |=>
      col_valid && ((col_out & ~blk_mask) == ($past(col_out) & ~blk_mask)));

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (rst)
    stop |=> !col_valid);

  p_err_only_on_set_r9: assert property (@(posedge clk) disable iff (rst)
    !mode_set |=> $stable(mode_err));

  p_err_keeps_mode_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_err) |-> $stable(cas_lat));

  p_first_beat_r10: assert property (@(posedge clk) disable iff (rst)
    start && !stop |=> col_valid && (col_out == $past(start_col)));

endmodule

bind bca_burst_colgen bca_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_set  (mode_set),
  .start     (start),
  .start_col (start_col),
  .stop      (stop),
  .col_out   (col_out),
  .col_valid (col_valid),
  .col_last  (col_last),
  .mode_err  (mode_err),
  .cas_lat   (cas_lat),
  .blk_mask  (blk_mask)
);

// File: tb/bca_burst_colgen_bench.sv
module bca_burst_colgen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_set = 1'b0;
  logic [11:0] mode_key = '0;
  logic        mode_bank = 1'b0;
  logic        start = 1'b0;
  logic        start_wr = 1'b0;
  logic [7:0]  start_col = '0;
  logic        stop = 1'b0;
  logic [7:0]  col_out;
  logic        col_valid, col_last, mode_err;
  logic [1:0]  cas_lat;

  int n_checks = 0;
  int n_err = 0;
  string cur_req = "R1";
  logic [8:0] sb_q[$];

  // reference model of the programmed mode
  int m_len = 1;
  bit m_il = 0;
  int m_cl = 2;
  bit m_ws = 0;

  always #2.5 clk = ~clk;

  bca_burst_colgen u_bca_burst_colgen (
    .clk(clk), .rst(rst), .mode_set(mode_set), .mode_key(mode_key),
    .mode_bank(mode_bank), .start(start), .start_wr(start_wr),
    .start_col(start_col), .stop(stop), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err),
    .cas_lat(cas_lat)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int i,
                                         input int len, input bit il);
    int mask;
    int low;
    mask = len - 1;
    low  = il ? ((int'(s) ^ i) & mask) : ((int'(s) + i) & mask);
    return 8'((int'(s) & ~mask) | low);
  endfunction

  // monitor: pops one expected beat per valid output cycle
  always @(negedge clk) begin
    if (!rst && col_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected beat", int'(col_out), 0);
      end else begin
        logic [8:0] item;
        item = sb_q.pop_front();
        chk(col_out == item[8:1], cur_req, "column", int'(col_out), int'(item[8:1]));
        chk(col_last == item[0], cur_req, "last flag", int'(col_last), int'(item[0]));
      end
    end
  end

  task automatic set_mode(input logic [11:0] key, input bit bank, input bit ok,
                          input int len, input bit il, input int cl, input bit ws,
                          input string req);
    cur_req = req;
    @(negedge clk);
    mode_set = 1'b1; mode_key = key; mode_bank = bank;
    @(negedge clk);
    mode_set = 1'b0; mode_key = '0; mode_bank = 1'b0;
    if (ok) begin
      m_len = len; m_il = il; m_cl = cl; m_ws = ws;
    end
    chk(mode_err == !ok, req, "mode_err", int'(mode_err), int'(!ok));
    chk(cas_lat == 2'(m_cl), req, "cas_lat", int'(cas_lat), m_cl);
  endtask

  // driver: pushes expected beats, pulses start, optionally stops after nstop beats
  task automatic do_burst(input logic [7:0] scol, input bit wr, input int nstop,
                          input string req);
    int len;
    int n;
    bit full;
    len  = (wr && m_ws) ? 1 : m_len;
    full = (len == 256);
    n    = (nstop > 0) ? nstop : len;
    cur_req = req;
    for (int i = 0; i < n; i++)
      sb_q.push_back({exp_col(scol, i, len, m_il), (!full && nstop == 0 && i == len - 1)});
    @(negedge clk);
    start = 1'b1; start_wr = wr; start_col = scol;
    @(negedge clk);
    start = 1'b0; start_wr = 1'b0;
    chk(col_valid == 1'b1, "R10", "first beat valid", int'(col_valid), 1);
    if (nstop > 0) begin
      repeat (nstop - 1) @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end else begin
      repeat (len) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, req, "beats missing", sb_q.size(), 0);
    chk(col_valid == 1'b0, req, "idle after burst", int'(col_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(col_valid == 1'b0, "R1", "col_valid", int'(col_valid), 0);
    chk(col_last == 1'b0, "R1", "col_last", int'(col_last), 0);
    chk(mode_err == 1'b0, "R1", "mode_err", int'(mode_err), 0);
    chk(cas_lat == 2'd2, "R1", "cas_lat", int'(cas_lat), 2);
    do_burst(8'h37, 1'b0, 0, "R1");

    // R2 / R3 / R4 sequential lengths
    set_mode(12'h033, 1'b0, 1'b1, 8, 1'b0, 3, 1'b0, "R2");
    do_burst(8'h45, 1'b0, 0, "R4");
    set_mode(12'h032, 1'b0, 1'b1, 4, 1'b0, 3, 1'b0, "R2");
    do_burst(8'h7E, 1'b0, 0, "R3");
    set_mode(12'h021, 1'b0, 1'b1, 2, 1'b0, 2, 1'b0, "R2");
    do_burst(8'hC3, 1'b0, 0, "R3");

    // R5 interleave
    set_mode(12'h03B, 1'b0, 1'b1, 8, 1'b1, 3, 1'b0, "R5");
    do_burst(8'hA5, 1'b0, 0, "R5");
    set_mode(12'h039, 1'b0, 1'b1, 2, 1'b1, 3, 1'b0, "R5");
    do_burst(8'h11, 1'b0, 0, "R5");
    set_mode(12'h02A, 1'b0, 1'b1, 4, 1'b1, 2, 1'b0, "R5");
    do_burst(8'h06, 1'b0, 0, "R5");

    // R9 rejected keys keep interleave length 4, CL 2
    set_mode(12'h034, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, "R9");
    set_mode(12'h012, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, "R9");
    set_mode(12'h03F, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, "R9");
    set_mode(12'h0B2, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, "R9");
    set_mode(12'h432, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, "R9");
    set_mode(12'h033, 1'b1, 1'b0, 0, 1'b0, 0, 1'b0, "R9");
    do_burst(8'h6D, 1'b0, 0, "R9");

    // R6 / R8 full page
    set_mode(12'h037, 1'b0, 1'b1, 256, 1'b0, 3, 1'b0, "R6");
    do_burst(8'hFC, 1'b0, 10, "R8");
    do_burst(8'h10, 1'b0, 262, "R6");

    // R7 single-beat writes
    set_mode(12'h223, 1'b0, 1'b1, 8, 1'b0, 2, 1'b1, "R7");
    do_burst(8'h33, 1'b1, 0, "R7");
    do_burst(8'h33, 1'b0, 0, "R7");
    set_mode(12'h023, 1'b0, 1'b1, 8, 1'b0, 2, 1'b0, "R7");
    do_burst(8'h5A, 1'b1, 0, "R7");

    // R8 stop on a fixed-length burst
    do_burst(8'h81, 1'b0, 3, "R8");

    // R10 restart during a burst
    cur_req = "R10";
    for (int i = 0; i < 3; i++) sb_q.push_back({exp_col(8'h20, i, 8, 1'b0), 1'b0});
    for (int i = 0; i < 8; i++) sb_q.push_back({exp_col(8'h5B, i, 8, 1'b0), (i == 7)});
    @(negedge clk); start = 1'b1; start_col = 8'h20;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); start = 1'b1; start_col = 8'h5B;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R10", "restart beats missing", sb_q.size(), 0);

    // R8 stop beats a start at the same edge
    @(negedge clk); start = 1'b1; stop = 1'b1; start_col = 8'h44;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    chk(col_valid == 1'b0, "R8", "stop with start", int'(col_valid), 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule